// File: doc/BRIEF.md
# Wall-Following Robot Controller

This block is the steering controller for a small robot with two contact antennae, one on the left and one on the right. It guides the robot through a maze by keeping the right antenna against a wall. Each clock cycle it reads the two contact sensors and drives three actuator commands: step forward, turn left and turn right.

The whole control law sits in a fixed lookup table. The current two-bit state and the two sensor bits form a 4-bit address, and each of the 16 words holds the next state and the three actuator bits. A register holds the state. The actuator bits in a word depend only on the current state, so the commands form a Moore output of the registered state. The commands change only on clock edges, whatever the sensors do between edges.

There are four behaviours. While searching, the robot walks forward until something touches. After a bump it rotates left until nothing touches. Next it steps while turning right to look for the wall again. When the right antenna finds the wall it steps while turning left, so that it follows the wall around corners.

Top module: `wallbot_ctrl`

## Requirements
- R1: `rst` is synchronous and active high. A rising edge with `rst`=1 puts the controller in the searching state, encoded 00, and its commands become {turn_r,turn_l,fwd}=001. Sensor values have no effect on that edge.
- R2: In the searching state (00) the next state is 00 when both sensors read 0, and the bump state (01) when either sensor reads 1.
- R3: In the bump state (01) the next state stays 01 while either sensor reads 1, and becomes the seek state (10) when both read 0.
- R4: In the seek state (10) the next state is 10 while the right sensor reads 0, whatever the left sensor reads, and the follow state (11) when the right sensor reads 1.
- R5: In the follow state (11) the next state is 01 when the left sensor reads 1. It is 10 when both sensors read 0, and it stays 11 when only the right sensor reads 1.
- R6: The commands {turn_r,turn_l,fwd} are 001 in state 00, 010 in 01, 101 in 10 and 011 in 11. turn_r and turn_l are never both 1.
- R7: The commands depend only on the registered state. A sensor change between clock edges leaves them unchanged until the next rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset to the searching state |
| sense_l | input | 1 | Left antenna contact, 1 = touching |
| sense_r | input | 1 | Right antenna contact, 1 = touching |
| fwd | output | 1 | Step forward command |
| turn_l | output | 1 | Left turn command |
| turn_r | output | 1 | Right turn command |

## Verification
The transition assertions assume that both sensors carry a defined 0 or 1 at every rising edge after reset, and that reset is held from time zero until the state register has been loaded once. The bench holds reset high from the first instant and drives both sensors to known values before the first edge. It changes them only on falling edges, so every sampled address is a defined table entry. The commands identify the state uniquely, so the bench reads the state through the actuator outputs alone.

// File: rtl/wallbot_pkg.sv
package wallbot_pkg;

    localparam int STATE_W = 2;
    localparam int SENS_W  = 2;
    localparam int CMD_W   = 3;
    localparam int ADDR_W  = STATE_W + SENS_W;
    localparam int DEPTH   = 1 << ADDR_W;
    localparam int WORD_W  = STATE_W + CMD_W;

    typedef enum logic [STATE_W-1:0] {
        ST_SEARCH = 2'b00,
        ST_BUMP   = 2'b01,
        ST_SEEK   = 2'b10,
        ST_FOLLOW = 2'b11
    } mode_e;

    // command bundle, ordered {turn_r, turn_l, fwd}
    typedef struct packed {
        logic turn_r;
        logic turn_l;
        logic fwd;
    } cmd_t;

    // one table word, ordered {next state, commands}
    typedef struct packed {
        mode_e nxt;
        cmd_t  cmd;
    } ctl_word_t;

    // Builds one table word from its address {state, left, right}.
    function automatic ctl_word_t build_word(input logic [ADDR_W-1:0] adr);
        ctl_word_t w;
        mode_e     cur;
        logic      lft;
        logic      rgt;
        cur = mode_e'(adr[ADDR_W-1:SENS_W]);
        lft = adr[1];
        rgt = adr[0];
        case (cur)
            ST_SEARCH: begin
                w.cmd = '{turn_r: 1'b0, turn_l: 1'b0, fwd: 1'b1};
                w.nxt = (lft || rgt) ? ST_BUMP : ST_SEARCH;
            end
            ST_BUMP: begin
                w.cmd = '{turn_r: 1'b0, turn_l: 1'b1, fwd: 1'b0};
                w.nxt = (lft || rgt) ? ST_BUMP : ST_SEEK;
            end
            ST_SEEK: begin
                w.cmd = '{turn_r: 1'b1, turn_l: 1'b0, fwd: 1'b1};
                w.nxt = rgt ? ST_FOLLOW : ST_SEEK;
            end
            default: begin
                w.cmd = '{turn_r: 1'b0, turn_l: 1'b1, fwd: 1'b1};
                if (lft)      w.nxt = ST_BUMP;
                else if (rgt) w.nxt = ST_FOLLOW;
                else          w.nxt = ST_SEEK;
            end
        endcase
        return w;
    endfunction

endpackage

// File: rtl/wallbot_table.sv
module wallbot_table
    import wallbot_pkg::*;
#(
    parameter int AW = ADDR_W
) (
    input  logic [AW-1:0] addr,
    output ctl_word_t     word
);
    localparam int N = 1 << AW;

    ctl_word_t rom [N];

    // constant contents filled at elaboration
    for (genvar i = 0; i < N; i++) begin : g_word
        assign rom[i] = build_word(ADDR_W'(i));
    end

    assign word = rom[addr];

endmodule

// File: rtl/wallbot_state.sv
module wallbot_state
    import wallbot_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  sense_l,
    input  logic  sense_r,
    input  mode_e nxt_tbl,
    output mode_e mode_q
);
    typedef struct packed {
        mode_e mode;
    } regs_t;

    regs_t r_d;
    regs_t r_q;

    always_comb begin
        r_d = r_q;
        r_d.mode = nxt_tbl;
        if (rst) r_d.mode = ST_SEARCH;
    end

    always_ff @(posedge clk) begin
        r_q <= r_d;
    end

    assign mode_q = r_q.mode;

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> mode_q == ST_SEARCH);

    // R2
    search_leave_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_q == ST_SEARCH && (sense_l || sense_r)) |=> mode_q == ST_BUMP);

    // R3
    bump_exit_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_q == ST_BUMP && !sense_l && !sense_r) |=> mode_q == ST_SEEK);

    // R4
    seek_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_q == ST_SEEK && !sense_r) |=> mode_q == ST_SEEK);

    // R5
    follow_left_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_q == ST_FOLLOW && sense_l) |=> mode_q == ST_BUMP);

endmodule

// File: rtl/wallbot_ctrl.sv
module wallbot_ctrl
    import wallbot_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic sense_l,
    input  logic sense_r,
    output logic fwd,
    output logic turn_l,
    output logic turn_r
);
    mode_e             mode_q;
    ctl_word_t         word;
    logic [ADDR_W-1:0] addr;

    assign addr = {mode_q, sense_l, sense_r};

    wallbot_table #(.AW(ADDR_W)) u_table (
        .addr (addr),
        .word (word)
    );

    wallbot_state u_state (
        .clk     (clk),
        .rst     (rst),
        .sense_l (sense_l),
        .sense_r (sense_r),
        .nxt_tbl (word.nxt),
        .mode_q  (mode_q)
    );

    assign fwd    = word.cmd.fwd;
    assign turn_l = word.cmd.turn_l;
    assign turn_r = word.cmd.turn_r;

    // R6
    no_turn_clash_chk: assert property (@(posedge clk) disable iff (rst)
        !(turn_l && turn_r));

    // R7
    moore_out_chk: assert property (@(posedge clk) disable iff (rst)
        $stable(mode_q) |-> $stable({turn_r, turn_l, fwd}));

endmodule

// File: tb/sim_wallbot_ctrl.sv
module sim_wallbot_ctrl;
    localparam int CLK_P = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sl  = 1'b0;
    logic sr  = 1'b0;
    logic fwd, turn_l, turn_r;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    wallbot_ctrl u0 (
        .clk(clk), .rst(rst), .sense_l(sl), .sense_r(sr),
        .fwd(fwd), .turn_l(turn_l), .turn_r(turn_r)
    );

    // expected {turn_r,turn_l,fwd} per state code
    function automatic logic [2:0] cmd_of(input logic [1:0] s);
        case (s)
            2'b00:   return 3'b001;
            2'b01:   return 3'b010;
            2'b10:   return 3'b101;
            default: return 3'b011;
        endcase
    endfunction

    function automatic logic [1:0] model_next(input logic [1:0] s, input logic l, input logic r);
        case (s)
            2'b00:   return (l | r) ? 2'b01 : 2'b00;
            2'b01:   return (l | r) ? 2'b01 : 2'b10;
            2'b10:   return r ? 2'b11 : 2'b10;
            default: return l ? 2'b01 : (r ? 2'b11 : 2'b10);
        endcase
    endfunction

    task automatic chk(input string req, input logic [2:0] exp);
        checks++;
        if ({turn_r, turn_l, fwd} !== exp) begin
            errors++;
            $display("FAIL %s: got %b expected %b", req, {turn_r, turn_l, fwd}, exp);
        end
    endtask

    // sensors set after a falling edge, one rising edge, back at falling edge
    task automatic step(input logic l, input logic r);
        sl = l; sr = r;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset(input logic l, input logic r);
        rst = 1'b1;
        step(l, r);
        rst = 1'b0;
    endtask

    task automatic go_to(input logic [1:0] s);
        do_reset(1'b0, 1'b0);
        if (s != 2'b00) step(1'b1, 1'b0);
        if (s[1])       step(1'b0, 1'b0);
        if (s == 2'b11) step(1'b0, 1'b1);
    endtask

    initial begin
        logic [1:0] st;
        logic [7:0] lfsr;
        string tag;
        @(negedge clk);
        @(negedge clk);
        chk("R1 reset state", 3'b001);
        do_reset(1'b1, 1'b1);
        chk("R1 reset ignores sensors", 3'b001);

        for (int s = 0; s < 4; s++) begin
            for (int lr = 0; lr < 4; lr++) begin
                go_to(2'(s));
                chk("R6 state command", cmd_of(2'(s)));
                sl = lr[1]; sr = lr[0];
                #(CLK_P/4);
                chk("R7 stable between edges", cmd_of(2'(s)));
                @(negedge clk);
                case (s)
                    0: tag = "R2 search transition";
                    1: tag = "R3 bump transition";
                    2: tag = "R4 seek transition";
                    default: tag = "R5 follow transition";
                endcase
                chk(tag, cmd_of(model_next(2'(s), lr[1], lr[0])));
            end
        end

        // pseudo-random maze walk against the model
        do_reset(1'b0, 1'b0);
        st = 2'b00;
        lfsr = 8'hA5;
        for (int n = 0; n < 400; n++) begin
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            if (n == 200) begin
                do_reset(lfsr[1], lfsr[0]);
                st = 2'b00;
                chk("R1 reset mid-walk", 3'b001);
            end else begin
                step(lfsr[1], lfsr[0]);
                st = model_next(st, lfsr[1], lfsr[0]);
                chk("R6 walk command", cmd_of(st));
                if (turn_l && turn_r) begin
                    errors++;
                    $display("FAIL R6: both turns %b expected not 11", {turn_r, turn_l});
                end
            end
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(CLK_P * 20000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule